// File: doc/BRIEF.md
# PWM Synchronous-Channel Update Controller

This block decides when new settings reach a group of PWM channels that run in lockstep. A processor writes staged values for the shared period, the shared dead time and the update interval through a small register port. A DMA-style write port supplies one duty word per synchronous channel. The block counts period boundaries of the group, and at those boundaries it copies staged values into the active copies that it drives to the waveform generator.

There are two independent commit paths. Period and dead time are committed at the first period boundary after software sets a pending flag. Duty words and the update interval are committed automatically once the programmed number of periods has passed, but only in automatic mode. A request/ready signal tells the DMA engine when to deliver the next set of duty words. It is raised either when an update interval ends or when a chosen compare unit matches. It drops once every synchronous channel has received its word.

Top module: `pwm_sync_update`

Register map (word index on `regAddr`): 0 configuration, 1 staged period, 2 staged dead time, 3 staged update interval, 4 control, 5 status, 6 interrupt mask. Configuration fields: bits [1:0] update mode (value 2 = automatic), bit 2 request trigger (0 = end of interval, 1 = compare match), bits [5:4] compare select, bit 8 group enable, bits [16+N-1:16] one sync bit per channel. Control bit 0 is the commit-pending flag. Status bit 0 is the sticky ready event and bit 1 is the live ready level. Mask bit 0 enables the interrupt.

## Requirements
- R1: After reset, all active period, dead-time and duty outputs are zero, `dmaReq`, `dmaReady` and `irq` are low, and the control and status registers read zero.
- R2: Writing 1 to control bit 0 sets a pending flag that reads back as 1 until the next `periodStart` pulse. At that pulse the staged period and dead time become active and the flag reads 0.
- R3: Writing the staged period or dead time without the pending flag leaves `actPeriod` and `actDeadTime` unchanged across period boundaries.
- R4: In automatic mode with an active interval value U, staged duty words become active on the (U+1)-th `periodStart` after the previous commit or after enable, and not before.
- R5: A staged interval value becomes the active interval at the next automatic commit, so it governs the interval that follows that commit.
- R6: Accepted DMA words (`dmaValid` high while `dmaReady` is high) go to the channels whose sync bit is set, in ascending channel index, skipping channels that are not synchronous.
- R7: `dmaReady` and `dmaReq` drop in the cycle after the word for the highest-indexed synchronous channel is accepted.
- R8: With request trigger 0, `dmaReq` rises when the group enters automatic mode and at each automatic commit.
- R9: With request trigger 1, `dmaReq` rises on `cmpMatch[select]` and not at the automatic commit, and a match on an unselected compare unit has no effect.
- R10: When the mode is not 2 or the group is disabled, `dmaReq` stays low and no duty commit happens.
- R11: Each rise of the ready level sets status bit 0. Reading the status register clears it. `irq` is high exactly while that bit and mask bit 0 are both set.
- R12: Disabling and re-enabling the group restarts the period count from zero and restarts duty delivery at the lowest synchronous channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (clears status on address 5) |
| regAddr | input | 3 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from `regAddr` |
| periodStart | input | 1 | One-cycle pulse at the start of each channel-0 period |
| cmpMatch | input | NUM_CMP | Compare-unit match pulses |
| dmaValid | input | 1 | DMA word valid |
| dmaData | input | DUTY_W | DMA duty word |
| dmaReady | output | 1 | Block accepts a DMA word this cycle |
| dmaReq | output | 1 | Request for a new set of duty words |
| irq | output | 1 | Ready-event interrupt |
| actPeriod | output | PER_W | Active shared period |
| actDeadTime | output | DT_W | Active shared dead time |
| dutyOut | output | NUM_CH*DUTY_W | Active duty per channel, channel c at bits [c*DUTY_W +: DUTY_W] |

## Verification
Checked on every cycle are the hold and release of the pending flag, the stability of period, dead time and duty away from period boundaries, the bound of the period counter against the active interval, the absence of a request outside automatic mode, and the masking of the interrupt. The bench sweeps every non-empty sync mask with changing interval values. That is the only way to see the order in which channels are steered, the exact boundary on which the commit lands, when an interval value takes effect, and how the request trigger selects between commit and compare. The restart on re-enable and the read-clear of the status are also shown only through scenarios.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_PER  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DT   = 3'd2;
  localparam logic [ADDR_W-1:0] A_UPR  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd5;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd6;

  localparam logic [1:0] MODE_AUTO = 2'd2;
  localparam int CFG_MODE_LSB = 0;
  localparam int CFG_TRIG_BIT = 2;
  localparam int CFG_SEL_LSB  = 4;
  localparam int CFG_EN_BIT   = 8;
  localparam int CFG_SYNC_LSB = 16;

  typedef struct packed {
    logic commitPerDt;
    logic commitAuto;
    logic dutyWr;
  } strobe_t;
endpackage

// File: rtl/pwm_sync_ctrl.sv
module pwm_sync_ctrl
  import pwm_sync_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_CMP = 2,
  parameter int UPR_W   = 4,
  localparam int SEL_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1,
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              periodStart,
  input  logic [NUM_CMP-1:0] cmpMatch,
  input  logic [1:0]        cfgMode,
  input  logic              cfgTrig,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic              cfgEn,
  input  logic [NUM_CH-1:0] cfgSync,
  input  logic [UPR_W-1:0]  actUpr,
  input  logic              unlockSet,
  input  logic              statusRead,
  input  logic              dmaValid,
  output strobe_t           strb,
  output logic [IDX_W-1:0]  dutyIdx,
  output logic              wrReady,
  output logic              unlockPend,
  output logic              readySticky,
  output logic [UPR_W-1:0]  upCnt
);
  logic autoOn, autoOnQ, enRise, periodDone, cmpHit, readySet, accept;
  logic [IDX_W-1:0] ptr, firstIdx, nextIdx;
  logic hasNext;

  assign autoOn     = cfgEn && (cfgMode == MODE_AUTO);
  assign enRise     = autoOn && !autoOnQ;
  assign periodDone = autoOn && !enRise && periodStart && (upCnt == actUpr);
  assign cmpHit     = cfgTrig ? cmpMatch[cfgSel] : periodDone;
  assign readySet   = (|cfgSync) && (enRise || (autoOn && cmpHit));
  assign accept     = dmaValid && wrReady;

  assign strb.commitPerDt = periodStart && unlockPend;
  assign strb.commitAuto  = periodDone;
  assign strb.dutyWr      = accept;
  assign dutyIdx          = ptr;

  always_comb begin
    firstIdx = '0;
    nextIdx  = '0;
    hasNext  = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cfgSync[i]) firstIdx = IDX_W'(i);
      if (cfgSync[i] && (i > int'(ptr))) begin
        nextIdx = IDX_W'(i);
        hasNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoOnQ <= 1'b0;
      upCnt   <= '0;
      wrReady <= 1'b0;
      ptr     <= '0;
    end else begin
      autoOnQ <= autoOn;
      if (!autoOn || enRise) upCnt <= '0;
      else if (periodStart) upCnt <= periodDone ? '0 : upCnt + 1'b1;

      if (!autoOn) begin
        wrReady <= 1'b0;
        ptr     <= '0;
      end else if (readySet) begin
        wrReady <= 1'b1;
        ptr     <= firstIdx;
      end else if (accept) begin
        if (hasNext) ptr <= nextIdx;
        else wrReady <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlockPend  <= 1'b0;
      readySticky <= 1'b0;
    end else begin
      if (unlockSet) unlockPend <= 1'b1;
      else if (periodStart) unlockPend <= 1'b0;
      if (readySet) readySticky <= 1'b1;
      else if (statusRead) readySticky <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_sync_dp.sv
module pwm_sync_dp
  import pwm_sync_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_CMP = 2,
  parameter int PER_W   = 16,
  parameter int DT_W    = 8,
  parameter int DUTY_W  = 16,
  parameter int UPR_W   = 4,
  localparam int SEL_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1,
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [31:0]              regWrData,
  output logic [31:0]              regRdData,
  input  strobe_t                  strb,
  input  logic [IDX_W-1:0]         dutyIdx,
  input  logic [DUTY_W-1:0]        dmaData,
  input  logic                     unlockPend,
  input  logic                     wrReady,
  input  logic                     readySticky,
  output logic [1:0]               cfgMode,
  output logic                     cfgTrig,
  output logic [SEL_W-1:0]         cfgSel,
  output logic                     cfgEn,
  output logic [NUM_CH-1:0]        cfgSync,
  output logic                     irqMask,
  output logic [UPR_W-1:0]         actUpr,
  output logic [PER_W-1:0]         actPeriod,
  output logic [DT_W-1:0]          actDeadTime,
  output logic [NUM_CH*DUTY_W-1:0] dutyOut
);
  logic [31:0]      cfgReg;
  logic [PER_W-1:0] stgPer;
  logic [DT_W-1:0]  stgDt;
  logic [UPR_W-1:0] stgUpr;

  assign cfgMode = cfgReg[CFG_MODE_LSB +: 2];
  assign cfgTrig = cfgReg[CFG_TRIG_BIT];
  assign cfgSel  = cfgReg[CFG_SEL_LSB +: SEL_W];
  assign cfgEn   = cfgReg[CFG_EN_BIT];
  assign cfgSync = cfgReg[CFG_SYNC_LSB +: NUM_CH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0; stgPer <= '0; stgDt <= '0; stgUpr <= '0; irqMask <= 1'b0;
      actPeriod <= '0; actDeadTime <= '0; actUpr <= '0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          A_CFG:   cfgReg  <= regWrData;
          A_PER:   stgPer  <= regWrData[PER_W-1:0];
          A_DT:    stgDt   <= regWrData[DT_W-1:0];
          A_UPR:   stgUpr  <= regWrData[UPR_W-1:0];
          A_MASK:  irqMask <= regWrData[0];
          default: ;
        endcase
      end
      if (strb.commitPerDt) begin
        actPeriod   <= stgPer;
        actDeadTime <= stgDt;
      end
      if (strb.commitAuto) actUpr <= stgUpr;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DUTY_W-1:0] stgDuty, actDuty;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stgDuty <= '0;
        actDuty <= '0;
      end else begin
        if (strb.dutyWr && (dutyIdx == IDX_W'(c))) stgDuty <= dmaData;
        if (strb.commitAuto) actDuty <= stgDuty;
      end
    end
    assign dutyOut[c*DUTY_W +: DUTY_W] = actDuty;
  end

  always_comb begin
    case (regAddr)
      A_CFG:   regRdData = cfgReg;
      A_PER:   regRdData = 32'(stgPer);
      A_DT:    regRdData = 32'(stgDt);
      A_UPR:   regRdData = 32'(stgUpr);
      A_CTRL:  regRdData = {31'b0, unlockPend};
      A_STAT:  regRdData = {30'b0, wrReady, readySticky};
      A_MASK:  regRdData = {31'b0, irqMask};
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/pwm_sync_update.sv
module pwm_sync_update
  import pwm_sync_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_CMP = 2,
  parameter int PER_W   = 16,
  parameter int DT_W    = 8,
  parameter int DUTY_W  = 16,
  parameter int UPR_W   = 4,
  localparam int SEL_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1,
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  logic                     regRdEn,
  input  logic [2:0]               regAddr,
  input  logic [31:0]              regWrData,
  output logic [31:0]              regRdData,
  input  logic                     periodStart,
  input  logic [NUM_CMP-1:0]       cmpMatch,
  input  logic                     dmaValid,
  input  logic [DUTY_W-1:0]        dmaData,
  output logic                     dmaReady,
  output logic                     dmaReq,
  output logic                     irq,
  output logic [PER_W-1:0]         actPeriod,
  output logic [DT_W-1:0]          actDeadTime,
  output logic [NUM_CH*DUTY_W-1:0] dutyOut
);
  strobe_t           strb;
  logic [IDX_W-1:0]  dutyIdx;
  logic              wrReady, unlockPend, readySticky, irqMask;
  logic [1:0]        cfgMode;
  logic              cfgTrig, cfgEn;
  logic [SEL_W-1:0]  cfgSel;
  logic [NUM_CH-1:0] cfgSync;
  logic [UPR_W-1:0]  actUpr, upCnt;
  logic              unlockSet, statusRead;

  assign unlockSet  = regWrEn && (regAddr == A_CTRL) && regWrData[0];
  assign statusRead = regRdEn && (regAddr == A_STAT);
  assign dmaReady   = wrReady;
  assign dmaReq     = wrReady;
  assign irq        = readySticky && irqMask;

  pwm_sync_ctrl #(.NUM_CH(NUM_CH), .NUM_CMP(NUM_CMP), .UPR_W(UPR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .periodStart(periodStart), .cmpMatch(cmpMatch),
    .cfgMode(cfgMode), .cfgTrig(cfgTrig), .cfgSel(cfgSel), .cfgEn(cfgEn),
    .cfgSync(cfgSync), .actUpr(actUpr), .unlockSet(unlockSet),
    .statusRead(statusRead), .dmaValid(dmaValid), .strb(strb),
    .dutyIdx(dutyIdx), .wrReady(wrReady), .unlockPend(unlockPend),
    .readySticky(readySticky), .upCnt(upCnt)
  );

  pwm_sync_dp #(.NUM_CH(NUM_CH), .NUM_CMP(NUM_CMP), .PER_W(PER_W), .DT_W(DT_W),
                .DUTY_W(DUTY_W), .UPR_W(UPR_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strb(strb),
    .dutyIdx(dutyIdx), .dmaData(dmaData), .unlockPend(unlockPend),
    .wrReady(wrReady), .readySticky(readySticky), .cfgMode(cfgMode),
    .cfgTrig(cfgTrig), .cfgSel(cfgSel), .cfgEn(cfgEn), .cfgSync(cfgSync),
    .irqMask(irqMask), .actUpr(actUpr), .actPeriod(actPeriod),
    .actDeadTime(actDeadTime), .dutyOut(dutyOut)
  );
endmodule

// File: rtl/pwm_sync_chk.sv
module pwm_sync_chk #(
  parameter int NUM_CH = 4,
  parameter int PER_W  = 16,
  parameter int DT_W   = 8,
  parameter int DUTY_W = 16,
  parameter int UPR_W  = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     periodStart,
  input logic                     unlockPend,
  input logic                     unlockSet,
  input logic [PER_W-1:0]         actPeriod,
  input logic [DT_W-1:0]          actDeadTime,
  input logic [NUM_CH*DUTY_W-1:0] dutyOut,
  input logic                     dmaReq,
  input logic [1:0]               cfgMode,
  input logic                     cfgEn,
  input logic [UPR_W-1:0]         upCnt,
  input logic [UPR_W-1:0]         actUpr,
  input logic                     irq,
  input logic                     irqMask
);
  logic autoOn;
  assign autoOn = cfgEn && (cfgMode == 2'd2);

  assert_unlock_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    unlockPend && !periodStart |=> unlockPend);
  assert_unlock_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    unlockPend && periodStart && !unlockSet |=> !unlockPend);
  assert_perdt_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(unlockPend && periodStart) |=> $stable(actPeriod) && $stable(actDeadTime));
  assert_duty_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !periodStart |=> $stable(dutyOut));
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    autoOn |-> upCnt <= actUpr);
  assert_req_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !autoOn |=> !dmaReq);
  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> irqMask);
endmodule

bind pwm_sync_update pwm_sync_chk #(
  .NUM_CH(NUM_CH), .PER_W(PER_W), .DT_W(DT_W), .DUTY_W(DUTY_W), .UPR_W(UPR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .periodStart(periodStart), .unlockPend(unlockPend),
  .unlockSet(unlockSet), .actPeriod(actPeriod), .actDeadTime(actDeadTime),
  .dutyOut(dutyOut), .dmaReq(dmaReq), .cfgMode(cfgMode), .cfgEn(cfgEn),
  .upCnt(upCnt), .actUpr(actUpr), .irq(irq), .irqMask(irqMask)
);

// File: tb/pwm_sync_update_tb.sv
module pwm_sync_update_tb;
  localparam int NCH = 4;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic periodStart = 1'b0;
  logic [1:0] cmpMatch = '0;
  logic dmaValid = 1'b0;
  logic [DW-1:0] dmaData = '0;
  logic dmaReady, dmaReq, irq;
  logic [15:0] actPeriod;
  logic [7:0] actDeadTime;
  logic [NCH*DW-1:0] dutyOut;

  int errors = 0;
  int checks = 0;
  int expStage[NCH];
  int expAct[NCH];
  int expUpr = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  pwm_sync_update u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .periodStart(periodStart), .cmpMatch(cmpMatch), .dmaValid(dmaValid),
    .dmaData(dmaData), .dmaReady(dmaReady), .dmaReq(dmaReq), .irq(irq),
    .actPeriod(actPeriod), .actDeadTime(actDeadTime), .dutyOut(dutyOut)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    tick();
    regRdEn = 1'b0;
  endtask

  task automatic pulse();
    periodStart = 1'b1;
    tick();
    periodStart = 1'b0;
  endtask

  task automatic cmpPulse(input int idx);
    cmpMatch[idx] = 1'b1;
    tick();
    cmpMatch = '0;
  endtask

  task automatic dmaPush(input int val, input int ch);
    chk(dmaReady == 1'b1, "R6 ready before word", dmaReady, 1);
    dmaValid = 1'b1; dmaData = DW'(val);
    tick();
    dmaValid = 1'b0;
    expStage[ch] = val;
  endtask

  function automatic logic [31:0] cfgWord(int mode, int trig, int sel, int en, int mask);
    return 32'(mode) | (32'(trig) << 2) | (32'(sel) << 4) | (32'(en) << 8) | (32'(mask) << 16);
  endfunction

  task automatic chkDuty(input string tag);
    for (int c = 0; c < NCH; c++)
      chk(int'(dutyOut[c*DW +: DW]) == expAct[c], tag, dutyOut[c*DW +: DW], expAct[c]);
  endtask

  task automatic fillAll(input int base, input logic [3:0] m);
    int k = 0;
    for (int c = 0; c < NCH; c++)
      if (m[c]) begin
        dmaPush(base + k, c);
        k++;
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin expStage[c] = 0; expAct[c] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();

    // R1 reset state
    chk(actPeriod == 0, "R1 period", actPeriod, 0);
    chk(actDeadTime == 0, "R1 deadtime", actDeadTime, 0);
    chkDuty("R1 duty");
    chk(!dmaReq && !dmaReady && !irq, "R1 req/irq", {dmaReq, dmaReady, irq}, 0);
    rdReg(3'd4, rd); chk(rd == 0, "R1 control", rd, 0);
    rdReg(3'd5, rd); chk(rd == 0, "R1 status", rd, 0);

    // R3 staged without pending flag
    wrReg(3'd1, 500); wrReg(3'd2, 7);
    pulse(); pulse();
    chk(actPeriod == 0, "R3 period held", actPeriod, 0);
    chk(actDeadTime == 0, "R3 deadtime held", actDeadTime, 0);

    // R2 pending flag
    wrReg(3'd4, 1);
    rdReg(3'd4, rd); chk(rd[0] == 1'b1, "R2 pending reads 1", rd[0], 1);
    repeat (5) tick();
    rdReg(3'd4, rd); chk(rd[0] == 1'b1, "R2 pending held", rd[0], 1);
    chk(actPeriod == 0, "R2 no early commit", actPeriod, 0);
    pulse();
    chk(actPeriod == 500, "R2 period commit", actPeriod, 500);
    chk(actDeadTime == 7, "R2 deadtime commit", actDeadTime, 7);
    rdReg(3'd4, rd); chk(rd[0] == 1'b0, "R2 pending cleared", rd[0], 0);

    // R10 non-automatic mode
    wrReg(3'd0, cfgWord(1, 0, 0, 1, 15)); tick();
    chk(dmaReq == 1'b0, "R10 no request mode 1", dmaReq, 0);
    repeat (3) pulse();
    chkDuty("R10 no duty commit");
    wrReg(3'd0, cfgWord(2, 0, 0, 0, 15)); tick();
    chk(dmaReq == 1'b0, "R10 no request disabled", dmaReq, 0);

    // Sweep of all sync masks, trigger 0
    wrReg(3'd6, 1);
    for (int m = 1; m < 16; m++) begin
      int u = (m % 3) + 1;
      wrReg(3'd0, 0); tick();
      rdReg(3'd5, rd);
      wrReg(3'd3, u);
      wrReg(3'd0, cfgWord(2, 0, 0, 1, m)); tick();
      chk(dmaReq == 1'b1, "R8 request at enable", dmaReq, 1);
      chk(irq == 1'b1, "R11 irq on ready event", irq, 1);
      fillAll(1000 + m * 8, 4'(m));
      chk(dmaReq == 1'b0 && dmaReady == 1'b0, "R7 drop after last word", dmaReq, 0);
      rdReg(3'd5, rd); chk(rd[1:0] == 2'b01, "R11 status sticky", rd[1:0], 1);
      rdReg(3'd5, rd); chk(rd[0] == 1'b0, "R11 read clears", rd[0], 0);
      chk(irq == 1'b0, "R11 irq cleared", irq, 0);
      repeat (expUpr) pulse();
      chkDuty("R4 R5 no commit before interval end");
      pulse();
      for (int c = 0; c < NCH; c++) expAct[c] = expStage[c];
      chkDuty("R6 R4 duty steering and commit");
      chk(dmaReq == 1'b1, "R8 request at commit", dmaReq, 1);
      expUpr = u;
    end

    // R12 restart on re-enable
    wrReg(3'd0, 0); tick();
    wrReg(3'd3, 3);
    wrReg(3'd0, cfgWord(2, 0, 0, 1, 15)); tick();
    fillAll(2000, 4'hF);
    repeat (expUpr + 1) pulse();
    for (int c = 0; c < NCH; c++) expAct[c] = expStage[c];
    chkDuty("R5 commit with prior interval");
    expUpr = 3;
    fillAll(3000, 4'hF);
    repeat (2) pulse();
    wrReg(3'd0, 0); tick();
    wrReg(3'd0, cfgWord(2, 0, 0, 1, 15)); tick();
    chk(dmaReq == 1'b1, "R12 request after re-enable", dmaReq, 1);
    fillAll(4000, 4'hF);
    chk(int'(dutyOut[DW-1:0]) == expAct[0], "R12 restart from lowest", dutyOut[DW-1:0], expAct[0]);
    repeat (3) pulse();
    chkDuty("R12 count restarted");
    pulse();
    for (int c = 0; c < NCH; c++) expAct[c] = expStage[c];
    chkDuty("R12 commit after full interval");

    // R9 compare trigger
    wrReg(3'd0, 0); tick();
    wrReg(3'd0, cfgWord(2, 1, 1, 1, 15)); tick();
    chk(dmaReq == 1'b1, "R8 request at enable trigger 1", dmaReq, 1);
    fillAll(5000, 4'hF);
    repeat (expUpr + 1) pulse();
    for (int c = 0; c < NCH; c++) expAct[c] = expStage[c];
    chkDuty("R9 commit in compare mode");
    chk(dmaReq == 1'b0, "R9 no request at commit", dmaReq, 0);
    cmpPulse(0);
    chk(dmaReq == 1'b0, "R9 unselected compare ignored", dmaReq, 0);
    cmpPulse(1);
    chk(dmaReq == 1'b1, "R9 selected compare raises", dmaReq, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule